// File: doc/BRIEF.md
# Dual-slot receive buffer controller

This block is the register and control front end of a small Ethernet MAC. Software sees a bank of 32-bit registers, each selected by a word index (the byte address divided by four). Two receive slots are provided. Software arms a slot by writing the "loaded" code into that slot's state register. When the receive path presents a frame, given as a one-cycle start strobe and a payload length, the block stores the frame's length as it sits in the buffer into the chosen slot's count register and marks that slot pending. Slot 0 has fixed priority over slot 1. A frame that finds no armed slot is not taken. The `frm_ready` output tells the upstream queue when it may retry.

The receive interrupt is a level that stays high as long as any slot is pending. For transmit, software writes the frame size in bytes, including the 8-byte preamble/SFD header and the 4-byte FCS, to the transmit count register. A non-zero write checks the size limits and the first eight buffer bytes, which are supplied on `tx_hdr`. It then pulses the transmit interrupt for one cycle. When the checks pass, it also pulses a send strobe carrying the payload length and clears the count register. Bit 0 of the setup register drives the PHY reset pin.

Top module: `rxslot_regif`

## Requirements
- R1: After reset every register reads 0 and `rx_irq`, `tx_irq`, `tx_send`, `frm_ready` and `phy_rst` are low.
- R2: The word index selects the register: 0 setup, 1 management, 2 slot 0 state, 3 slot 0 count, 4 slot 1 state, 5 slot 1 count, 6 transmit count. The setup, management and transmit count words read back the full written word (a transmit count write that passes the checks is the exception, see R9). Any other index reads 0, and writes to it change nothing.
- R3: `phy_rst` equals bit 0 of the setup register.
- R4: A state register keeps bits [1:0] of the written word: 0 empty, 1 loaded, 2 pending. Code 3 counts as neither loaded nor pending. A count register keeps bits [11:0]. Unused upper bits read 0.
- R5: A frame start goes to slot 0 if its state is 1, otherwise to slot 1 if its state is 1. `frm_ready` is high exactly when some state is 1. A start that arrives while `frm_ready` is low changes nothing.
- R6: On acceptance, the slot's count becomes max(payload, 60) + 12 and its state becomes 2. This is visible after the accepting clock edge. If that length exceeds 2048, the frame is dropped and both registers of the slot stay as they were.
- R7: `rx_irq` is high exactly when at least one slot state equals 2. This also holds after software writes to a state register.
- R8: A write of a non-zero value to the transmit count raises `tx_irq` for exactly the one cycle after the write edge. This happens whether the checks pass or fail. A write of 0 gives no pulse.
- R9: The transmit checks pass when the count is between 64 and 1530 inclusive and `tx_hdr` holds bytes 0 to 6 equal to 0x55 and byte 7 equal to 0xD5, where byte k is bits [8k+7:8k]. On a pass, `tx_send` pulses together with `tx_irq`, `tx_len` equals count - 12 and the count register reads 0. On a failure there is no send and the written count stays.
- R10: When a frame is accepted into a slot in the same cycle that software writes that slot's state or count, the frame's update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_word | input | 3 | Register word index (byte address / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_word`, combinational |
| frm_start | input | 1 | One-cycle strobe: a received frame is offered |
| frm_len | input | 12 | Payload length of the offered frame in bytes |
| frm_ready | output | 1 | A slot is armed, so a frame may be offered |
| tx_hdr | input | 64 | First eight bytes of the transmit buffer |
| rx_irq | output | 1 | Receive interrupt level |
| tx_irq | output | 1 | Transmit interrupt pulse |
| tx_send | output | 1 | Transmit accepted strobe |
| tx_len | output | 12 | Payload length sent with `tx_send` |
| phy_rst | output | 1 | PHY reset control |

## Verification
The bench builds the block with its default parameters: two slots, a 3-bit word index, 12-bit lengths, a 2048-byte buffer and transmit limits of 64 and 1530. At this size every transmit count from 0 to 1600 is tried against both limits. Every payload length from 0 to 2100 is offered, with a stride above that up to 4095, which covers both the padding threshold and the oversize cut. All nine state pairs of the two slots are swept for priority, readiness and interrupt. Every word index and every corrupted header byte position are also exercised.

// File: rtl/rxslot_pkg.sv
package rxslot_pkg;

  typedef enum logic [1:0] {
    SLOT_EMPTY   = 2'd0,
    SLOT_LOADED  = 2'd1,
    SLOT_PENDING = 2'd2
  } slot_state_e;

  localparam logic [7:0] PREAMBLE_BYTE = 8'h55;
  localparam logic [7:0] SFD_BYTE      = 8'hD5;

  // Buffer length of a received frame: padded payload plus header and FCS.
  function automatic logic [31:0] frame_bytes(input logic [31:0] payload,
                                               input logic [31:0] min_frame,
                                               input logic [31:0] overhead);
    logic [31:0] body;
    body = (payload < min_frame) ? min_frame : payload;
    return body + overhead;
  endfunction

  function automatic logic tx_size_ok(input logic [31:0] cnt,
                                      input logic [31:0] lo,
                                      input logic [31:0] hi);
    return (cnt >= lo) && (cnt <= hi);
  endfunction

  function automatic logic tx_head_ok(input logic [63:0] hdr);
    logic ok;
    ok = (hdr[63:56] == SFD_BYTE);
    for (int k = 0; k < 7; k++) begin
      if (hdr[8*k +: 8] != PREAMBLE_BYTE) ok = 1'b0;
    end
    return ok;
  endfunction

endpackage

// File: rtl/rxslot_arbiter.sv
module rxslot_arbiter #(
  parameter int NUM_SLOTS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] loaded,
  output logic [NUM_SLOTS-1:0] grant,
  output logic                 any_loaded
);

  logic [NUM_SLOTS:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_prio
    assign grant[i]    = loaded[i] & ~seen[i];
    assign seen[i + 1] = seen[i] | loaded[i];
  end

  assign any_loaded = seen[NUM_SLOTS];

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R5
  AST_GRANT_IS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~loaded) == '0); // R5
  AST_READY_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
    any_loaded |-> (grant != '0)); // R5

endmodule

// File: rtl/rxslot_slot.sv
module rxslot_slot
  import rxslot_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_we,
  input  logic             cnt_we,
  input  logic [1:0]       wr_state,
  input  logic [CNT_W-1:0] wr_count,
  input  logic             accept,
  input  logic [CNT_W-1:0] accept_cnt,
  output logic [1:0]       state,
  output logic [CNT_W-1:0] count,
  output logic             loaded,
  output logic             pending
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SLOT_EMPTY;
      count <= '0;
    end else if (accept) begin
      state <= SLOT_PENDING;
      count <= accept_cnt;
    end else begin
      if (st_we)  state <= wr_state;
      if (cnt_we) count <= wr_count;
    end
  end

  assign loaded  = (state == SLOT_LOADED);
  assign pending = (state == SLOT_PENDING);

  AST_ACCEPT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (pending && count == $past(accept_cnt))); // R6
  AST_ACCEPT_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> loaded); // R5

endmodule

// File: rtl/rxslot_txcheck.sv
module rxslot_txcheck
  import rxslot_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 12,
  parameter int TX_MIN = 64,
  parameter int TX_MAX = 1530,
  parameter int OVH    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] count_in,
  input  logic [63:0]       hdr,
  output logic              pass,
  output logic              irq,
  output logic              send,
  output logic [LEN_W-1:0]  len
);

  assign pass = tx_head_ok(hdr) &&
                tx_size_ok(32'(count_in), 32'(TX_MIN), 32'(TX_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq  <= 1'b0;
      send <= 1'b0;
      len  <= '0;
    end else begin
      irq  <= start;
      send <= start && pass;
      len  <= (start && pass) ? LEN_W'(count_in - DATA_W'(OVH)) : '0;
    end
  end

  AST_TX_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(start)); // R8
  AST_SEND_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    send |-> irq); // R9
  AST_SEND_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    send |-> (32'(len) == $past(32'(count_in)) - 32'(OVH))); // R9

endmodule

// File: rtl/rxslot_regif.sv
module rxslot_regif
  import rxslot_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int WORD_W    = 3,
  parameter int NUM_SLOTS = 2,
  parameter int LEN_W     = 12,
  parameter int BUF_BYTES = 2048,
  parameter int MIN_FRAME = 60,
  parameter int FRAME_OVH = 12,
  parameter int TX_MIN    = 64,
  parameter int TX_MAX    = 1530
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [WORD_W-1:0] bus_word,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              frm_start,
  input  logic [LEN_W-1:0]  frm_len,
  output logic              frm_ready,
  input  logic [63:0]       tx_hdr,
  output logic              rx_irq,
  output logic              tx_irq,
  output logic              tx_send,
  output logic [LEN_W-1:0]  tx_len,
  output logic              phy_rst
);

  localparam int CNT_W   = $clog2(BUF_BYTES) + 1;
  localparam int W_SETUP = 0;
  localparam int W_MGMT  = 1;
  localparam int W_TXCNT = 2 + 2 * NUM_SLOTS;

  logic [DATA_W-1:0]    setup_q, mgmt_q, txcnt_q;
  logic [1:0]           st  [NUM_SLOTS];
  logic [CNT_W-1:0]     cnt [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] loaded, pending, grant, accept_vec, wr_st, wr_cnt;
  logic                 any_loaded;

  // Receive length calculation
  logic [31:0]      asm_bytes;
  logic             too_big, frm_take;
  logic [CNT_W-1:0] asm_cnt;

  assign asm_bytes = frame_bytes(32'(frm_len), 32'(MIN_FRAME), 32'(FRAME_OVH));
  assign too_big   = asm_bytes > 32'(BUF_BYTES);
  assign asm_cnt   = CNT_W'(asm_bytes);
  assign frm_take  = frm_start && !too_big;
  assign accept_vec = grant & {NUM_SLOTS{frm_take}};

  rxslot_arbiter #(.NUM_SLOTS(NUM_SLOTS)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .loaded     (loaded),
    .grant      (grant),
    .any_loaded (any_loaded)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign wr_st[i]  = bus_we && (bus_word == WORD_W'(2 + 2 * i));
    assign wr_cnt[i] = bus_we && (bus_word == WORD_W'(3 + 2 * i));

    rxslot_slot #(.CNT_W(CNT_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .st_we      (wr_st[i]),
      .cnt_we     (wr_cnt[i]),
      .wr_state   (bus_wdata[1:0]),
      .wr_count   (bus_wdata[CNT_W-1:0]),
      .accept     (accept_vec[i]),
      .accept_cnt (asm_cnt),
      .state      (st[i]),
      .count      (cnt[i]),
      .loaded     (loaded[i]),
      .pending    (pending[i])
    );
  end

  // Transmit request
  logic tx_start, tx_pass;
  assign tx_start = bus_we && (bus_word == WORD_W'(W_TXCNT)) && (|bus_wdata);

  rxslot_txcheck #(
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W),
    .TX_MIN (TX_MIN),
    .TX_MAX (TX_MAX),
    .OVH    (FRAME_OVH)
  ) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (tx_start),
    .count_in (bus_wdata),
    .hdr      (tx_hdr),
    .pass     (tx_pass),
    .irq      (tx_irq),
    .send     (tx_send),
    .len      (tx_len)
  );

  // Plain registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      setup_q <= '0;
      mgmt_q  <= '0;
      txcnt_q <= '0;
    end else if (bus_we) begin
      if (bus_word == WORD_W'(W_SETUP)) setup_q <= bus_wdata;
      if (bus_word == WORD_W'(W_MGMT))  mgmt_q  <= bus_wdata;
      if (bus_word == WORD_W'(W_TXCNT)) txcnt_q <= (tx_start && tx_pass) ? '0 : bus_wdata;
    end
  end

  // Read decode
  always_comb begin
    bus_rdata = '0;
    if (bus_word == WORD_W'(W_SETUP)) bus_rdata = setup_q;
    if (bus_word == WORD_W'(W_MGMT))  bus_rdata = mgmt_q;
    if (bus_word == WORD_W'(W_TXCNT)) bus_rdata = txcnt_q;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (bus_word == WORD_W'(2 + 2 * i)) bus_rdata = {{(DATA_W-2){1'b0}}, st[i]};
      if (bus_word == WORD_W'(3 + 2 * i)) bus_rdata = {{(DATA_W-CNT_W){1'b0}}, cnt[i]};
    end
  end

  assign frm_ready = any_loaded;
  assign rx_irq    = |pending;
  assign phy_rst   = setup_q[0];

  AST_TXCNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    tx_send |-> (txcnt_q == '0)); // R9
  AST_REJECT_NO_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_start && !frm_ready && !bus_we) |=> $stable(pending)); // R5
  AST_BIG_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_start && too_big && !bus_we) |=> $stable(pending)); // R6

endmodule

// File: tb/rxslot_regif_bench.sv
module rxslot_regif_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_word = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        frm_start = 1'b0;
  logic [11:0] frm_len = '0;
  logic        frm_ready;
  logic [63:0] tx_hdr = 64'hD555_5555_5555_5555;
  logic        rx_irq, tx_irq, tx_send, phy_rst;
  logic [11:0] tx_len;

  localparam logic [63:0] GOOD_HDR = 64'hD555_5555_5555_5555;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rxslot_regif u_rxslot_regif (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frm_start(frm_start),
    .frm_len(frm_len), .frm_ready(frm_ready), .tx_hdr(tx_hdr),
    .rx_irq(rx_irq), .tx_irq(tx_irq), .tx_send(tx_send), .tx_len(tx_len),
    .phy_rst(phy_rst)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] w, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_word = w; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] w, output logic [31:0] d);
    bus_word = w;
    #1;
    d = bus_rdata;
  endtask

  task automatic frame(input int p);
    @(negedge clk);
    frm_start = 1'b1; frm_len = 12'(p);
    @(negedge clk);
    frm_start = 1'b0;
  endtask

  function automatic logic [31:0] exp_read(input int w, input logic [31:0] d);
    case (w)
      0, 1, 6: return d;
      2, 4:    return d & 32'h3;
      3, 5:    return d & 32'hFFF;
      default: return 32'h0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, exp;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int w = 0; w < 8; w++) begin
      rd(3'(w), d);
      check(d == 0, "R1 reset read", d, 0);
    end
    check({rx_irq, tx_irq, tx_send, frm_ready, phy_rst} == 5'b0, "R1 reset outputs",
          {rx_irq, tx_irq, tx_send, frm_ready, phy_rst}, 0);

    // R2/R4: every word index, readback masks; transmit count above the limit so it stays
    for (int w = 0; w < 8; w++) begin
      d = (w == 2 || w == 4) ? 32'hA5C0_0000 : 32'hA5C0_7F00 + 32'(w);
      wr(3'(w), d);
      exp = exp_read(w, d);
      rd(3'(w), d);
      check(d == exp, $sformatf("R2 word %0d readback", w), d, exp);
    end
    for (int w = 0; w < 8; w++) wr(3'(w), 0);
    for (int w = 0; w < 8; w++) begin
      rd(3'(w), d);
      check(d == 0, "R2 cleared", d, 0);
    end

    // R3: PHY reset follows setup bit 0
    wr(0, 32'h1);
    check(phy_rst == 1'b1, "R3 phy_rst set", phy_rst, 1);
    wr(0, 32'hFFFF_FFFE);
    check(phy_rst == 1'b0, "R3 phy_rst clear", phy_rst, 0);
    wr(0, 0);

    // R4: state code 3 neither loaded nor pending
    wr(2, 3); wr(4, 3);
    check(frm_ready == 0 && rx_irq == 0, "R4 code3 inert", {frm_ready, rx_irq}, 0);
    rd(2, d);
    check(d == 3, "R4 code3 readback", d, 3);

    // R5/R7: all nine state pairs
    for (int s0 = 0; s0 < 3; s0++) begin
      for (int s1 = 0; s1 < 3; s1++) begin
        int e0, e1;
        wr(3, 0); wr(5, 0);
        wr(2, 32'(s0)); wr(4, 32'(s1));
        check(frm_ready == (s0 == 1 || s1 == 1), "R5 ready", frm_ready, 32'(s0 == 1 || s1 == 1));
        check(rx_irq == (s0 == 2 || s1 == 2), "R7 irq after state write", rx_irq, 32'(s0 == 2 || s1 == 2));
        frame(100);
        e0 = s0; e1 = s1;
        if (s0 == 1) e0 = 2; else if (s1 == 1) e1 = 2;
        rd(2, d); check(d == 32'(e0), "R5 slot0 state", d, 32'(e0));
        rd(4, d); check(d == 32'(e1), "R5 slot1 state", d, 32'(e1));
        rd(3, d); exp = (s0 == 1) ? 112 : 0;
        check(d == exp, "R5 slot0 count", d, exp);
        rd(5, d); exp = (s0 != 1 && s1 == 1) ? 112 : 0;
        check(d == exp, "R5 slot1 count", d, exp);
        check(rx_irq == (e0 == 2 || e1 == 2), "R7 irq after frame", rx_irq, 32'(e0 == 2 || e1 == 2));
      end
    end
    wr(2, 0); wr(4, 0);
    check(rx_irq == 0, "R7 irq falls", rx_irq, 0);

    // R6: payload length sweep into slot 0
    for (int p = 0; p < 4096; p += (p < 2100 ? 1 : 7)) begin
      int a;
      bit big;
      a = ((p < 60) ? 60 : p) + 12;
      big = (a > 2048);
      wr(3, 32'h0EE);
      wr(2, 1);
      frame(p);
      rd(3, d); exp = big ? 32'h0EE : 32'(a);
      check(d == exp, $sformatf("R6 count p=%0d", p), d, exp);
      rd(2, d); exp = big ? 1 : 2;
      check(d == exp, $sformatf("R6 state p=%0d", p), d, exp);
      wr(2, 0);
    end

    // R10: frame update wins over same-cycle software writes
    wr(2, 1);
    @(negedge clk);
    bus_we = 1; bus_word = 2; bus_wdata = 0; frm_start = 1; frm_len = 200;
    @(negedge clk);
    bus_we = 0; frm_start = 0;
    rd(2, d); check(d == 2, "R10 state write loses", d, 2);
    wr(2, 1);
    @(negedge clk);
    bus_we = 1; bus_word = 3; bus_wdata = 5; frm_start = 1; frm_len = 300;
    @(negedge clk);
    bus_we = 0; frm_start = 0;
    rd(3, d); check(d == 312, "R10 count write loses", d, 312);
    wr(2, 0);

    // R8/R9: transmit count sweep with a good header
    tx_hdr = GOOD_HDR;
    for (int c = 0; c <= 1600; c++) begin
      bit ok;
      ok = (c >= 64 && c <= 1530);
      wr(6, 32'(c));
      check(tx_irq == (c != 0), $sformatf("R8 irq c=%0d", c), tx_irq, 32'(c != 0));
      check(tx_send == ok, $sformatf("R9 send c=%0d", c), tx_send, 32'(ok));
      if (ok) check(tx_len == 12'(c - 12), "R9 len", tx_len, 32'(c - 12));
      rd(6, d); exp = ok ? 0 : 32'(c);
      check(d == exp, "R9 count after", d, exp);
      @(negedge clk);
      check(tx_irq == 0 && tx_send == 0, "R8 single pulse", {tx_irq, tx_send}, 0);
    end

    // R9: each header byte corrupted
    for (int k = 0; k < 8; k++) begin
      tx_hdr = GOOD_HDR ^ (64'h01 << (8 * k));
      wr(6, 100);
      check(tx_irq == 1 && tx_send == 0, $sformatf("R9 bad hdr byte %0d", k),
            {tx_irq, tx_send}, 2);
      rd(6, d); check(d == 100, "R9 count kept", d, 100);
    end
    tx_hdr = GOOD_HDR;

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule